// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between a byte-wide processor bus and three interval-timer channels. It turns bus cycles into channel configuration: a write to the configuration address carries a channel number, a byte-access format, an operating mode and a decimal/binary flag. These values are stored per channel and presented to the counters. Writes to a channel's data address are gathered into a 16-bit reload value. The value goes out to that channel with a one-cycle load strobe, but only after the last byte the format calls for has arrived. A counter does not start before its count is complete.

Reads of a channel's data address return bytes of that channel's current count in the programmed order. A snapshot command, issued through the configuration address, freezes the current count in a per-channel holding register. Reads then take their bytes from the snapshot until the whole value has been read, and afterwards return to the live count. The bus is sampled synchronously. Each assertion of a read or write strobe counts as exactly one access, however many clock cycles it is held.

Top module: `timer_bus_regs`

## Requirements
- R1: A write access (cs_n=0, wr_n=0, rd_n=1) to addr=3 is a configuration word. Bits 7:6 pick the channel (0..2). When bits 5:4 are nonzero, the word updates that channel's mode, format and decimal flag, and cfg_stb bit N goes high for exactly one cycle. A configuration word with bits 7:6 = 3 changes nothing and raises no strobe.
- R2: The configuration word's bits 3:1 give the mode and bit 0 gives the decimal flag (cfg_bcd). The stored mode is the written code, except that 6 is stored as 2 and 7 is stored as 3. Bits 5:4 appear on cfg_fmt: 1 = low byte only, 2 = high byte only, 3 = low then high.
- R3: In format 1, each data write to addr=N (0..2) pulses load_stb bit N for one cycle, with load_val slice N equal to {8'h00, byte}.
- R4: In format 2, each data write pulses load_stb bit N, with load_val slice N equal to {byte, 8'h00}.
- R5: In format 3, the first data write raises no strobe. The second write pulses load_stb bit N, with load_val slice N equal to {second byte, first byte}. Later writes repeat this pairing.
- R6: A configuration word to a channel returns both its write and its read byte order to the low byte, discarding a half-written count.
- R7: Without a snapshot, a read of addr=N returns bytes of live_cnt slice N on dout in the cycle after the read begins. Format 1 returns the low byte, format 2 the high byte, and format 3 alternates between low and high, starting with low.
- R8: A configuration word with bits 5:4 = 0 captures live_cnt slice N. Reads return bytes of the captured value until every byte of the format has been read once; after that, reads return the live count again.
- R9: A snapshot command issued while a snapshot is still unread is ignored, and the first captured value is kept.
- R10: A snapshot command leaves the channel's mode, format and decimal flag unchanged and raises no cfg_stb.
- R11: No access happens while cs_n=1, or while rd_n and wr_n are both low. A strobe held low for several cycles counts as one access.
- R12: After reset every channel reports mode 0, binary, format 1, with no strobes raised and dout equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register address: 0..2 channel data, 3 configuration |
| din | input | 8 | Write data byte |
| dout | output | 8 | Read data byte, registered |
| live_cnt | input | 48 | Current count of each channel, 16 bits per channel |
| cfg_mode | output | 9 | Normalised mode, 3 bits per channel |
| cfg_bcd | output | 3 | Decimal-count flag per channel |
| cfg_fmt | output | 6 | Byte-access format, 2 bits per channel |
| cfg_stb | output | 3 | One-cycle pulse per channel on a configuration write |
| load_stb | output | 3 | One-cycle pulse per channel when a full count is written |
| load_val | output | 48 | Assembled count, 16 bits per channel |

## Verification
The bench sweeps every mode code with both decimal settings on all three channels. A design that failed to fold modes 6 and 7 would report them as they were written. It writes counts in each format with edge-value bytes. A wrong byte pointer would show up as swapped halves, or as a load strobe after the first byte of a pair. It checks that a configuration word in the middle of a pair discards the stray low byte, and that a second snapshot command does not overwrite the first. It checks that a snapshot is released only after the last byte of its format has been read. It also holds a strobe low for several cycles to catch a design that counts by level instead of by access.

// File: rtl/timer_bus_pkg.sv
package timer_bus_pkg;

    typedef enum logic [1:0] {
        FMT_SNAP = 2'b00,
        FMT_LO   = 2'b01,
        FMT_HI   = 2'b10,
        FMT_PAIR = 2'b11
    } fmt_e;

    localparam logic [1:0] CFG_ADDR = 2'b11;

    function automatic logic [2:0] fold_mode(input logic [2:0] code);
        return code[1] ? {1'b0, code[1:0]} : code;
    endfunction

endpackage

// File: rtl/tbr_decode.sv
module tbr_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic       cfg_wr_o,
    output logic       dat_wr_o,
    output logic       dat_rd_o
);
    import timer_bus_pkg::*;

    typedef struct packed {
        logic wr_seen;
        logic rd_seen;
    } dec_t;

    dec_t q, d;
    logic wr_act, rd_act, wr_new, rd_new;

    always_comb begin
        wr_act   = !cs_n && !wr_n && rd_n;
        rd_act   = !cs_n && !rd_n && wr_n;
        wr_new   = wr_act && !q.wr_seen;
        rd_new   = rd_act && !q.rd_seen;
        cfg_wr_o = wr_new && (addr == CFG_ADDR);
        dat_wr_o = wr_new && (addr != CFG_ADDR);
        dat_rd_o = rd_new && (addr != CFG_ADDR);
        d.wr_seen = wr_act;
        d.rd_seen = rd_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R11: at most one kind of access per cycle, and a held strobe yields one access
    assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr_o, dat_wr_o, dat_rd_o}));
    assert_no_repeat_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_o || cfg_wr_o) |=> !(dat_wr_o || cfg_wr_o));
    assert_select_needed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr_o || dat_rd_o || cfg_wr_o) |-> !cs_n);

endmodule

// File: rtl/tbr_channel.sv
module tbr_channel #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_i,
    input  logic              dat_wr_i,
    input  logic              dat_rd_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [CNT_W-1:0]  live_i,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic [2:0]        mode_o,
    output logic              bcd_o,
    output logic [1:0]        fmt_o,
    output logic              cfg_stb_o,
    output logic              load_stb_o,
    output logic [CNT_W-1:0]  load_val_o
);
    import timer_bus_pkg::*;

    localparam int HALF = CNT_W / 2;

    typedef struct packed {
        logic [2:0]       mode;
        logic             bcd;
        fmt_e             fmt;
        logic             wr_hi;
        logic             rd_hi;
        logic [HALF-1:0]  lo_part;
        logic             held;
        logic [CNT_W-1:0] snap;
        logic             cfg_stb;
        logic             load_stb;
        logic [CNT_W-1:0] load_val;
    } ch_t;

    ch_t q, d;
    logic [CNT_W-1:0] src;
    logic             rd_last;
    logic             snap_cmd;

    always_comb begin
        src      = q.held ? q.snap : live_i;
        snap_cmd = cfg_wr_i && (din_i[5:4] == FMT_SNAP);
        unique case (q.fmt)
            FMT_HI:   begin rd_byte_o = src[CNT_W-1:HALF]; rd_last = 1'b1;    end
            FMT_PAIR: begin
                rd_byte_o = q.rd_hi ? src[CNT_W-1:HALF] : src[HALF-1:0];
                rd_last   = q.rd_hi;
            end
            default:  begin rd_byte_o = src[HALF-1:0];     rd_last = 1'b1;    end
        endcase

        d          = q;
        d.cfg_stb  = 1'b0;
        d.load_stb = 1'b0;

        if (snap_cmd) begin
            if (!q.held) begin
                d.held = 1'b1;
                d.snap = live_i;
            end
        end else if (cfg_wr_i) begin
            d.mode    = fold_mode(din_i[3:1]);
            d.bcd     = din_i[0];
            d.fmt     = fmt_e'(din_i[5:4]);
            d.wr_hi   = 1'b0;
            d.rd_hi   = 1'b0;
            d.held    = 1'b0;
            d.cfg_stb = 1'b1;
        end else if (dat_wr_i) begin
            unique case (q.fmt)
                FMT_HI: begin
                    d.load_stb = 1'b1;
                    d.load_val = {din_i, {HALF{1'b0}}};
                end
                FMT_PAIR: begin
                    if (q.wr_hi) begin
                        d.load_stb = 1'b1;
                        d.load_val = {din_i, q.lo_part};
                        d.wr_hi    = 1'b0;
                    end else begin
                        d.lo_part = din_i;
                        d.wr_hi   = 1'b1;
                    end
                end
                default: begin
                    d.load_stb = 1'b1;
                    d.load_val = {{HALF{1'b0}}, din_i};
                end
            endcase
        end else if (dat_rd_i) begin
            if (q.fmt == FMT_PAIR) d.rd_hi = !q.rd_hi;
            if (rd_last)           d.held  = 1'b0;
        end

        mode_o     = q.mode;
        bcd_o      = q.bcd;
        fmt_o      = q.fmt;
        cfg_stb_o  = q.cfg_stb;
        load_stb_o = q.load_stb;
        load_val_o = q.load_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.fmt <= FMT_LO;
        end else begin
            q <= d;
        end
    end

    assert_mode_folded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.mode[2] && q.mode[1]));
    assert_load_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.load_stb |-> $past(dat_wr_i));
    assert_load_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.load_stb |=> !q.load_stb);
    assert_snap_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_cmd && q.held) |=> $stable(q.snap));
    assert_snap_keeps_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        snap_cmd |=> ($stable(q.mode) && $stable(q.fmt) && $stable(q.bcd) && !q.cfg_stb));

endmodule

// File: rtl/timer_bus_regs.sv
module timer_bus_regs #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic [1:0]               addr,
    input  logic [DATA_W-1:0]        din,
    output logic [DATA_W-1:0]        dout,
    input  logic [NUM_CH*CNT_W-1:0]  live_cnt,
    output logic [NUM_CH*3-1:0]      cfg_mode,
    output logic [NUM_CH-1:0]        cfg_bcd,
    output logic [NUM_CH*2-1:0]      cfg_fmt,
    output logic [NUM_CH-1:0]        cfg_stb,
    output logic [NUM_CH-1:0]        load_stb,
    output logic [NUM_CH*CNT_W-1:0]  load_val
);
    typedef struct packed {
        logic [DATA_W-1:0] dout;
    } top_t;

    top_t q, d;
    logic cfg_wr, dat_wr, dat_rd;
    logic [DATA_W-1:0] rd_bytes [NUM_CH];

    tbr_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .cfg_wr_o (cfg_wr),
        .dat_wr_o (dat_wr),
        .dat_rd_o (dat_rd)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit_cfg, hit_addr;
        assign hit_cfg  = (din[7:6] == 2'(i));
        assign hit_addr = (addr == 2'(i));
        tbr_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_wr_i   (cfg_wr && hit_cfg),
            .dat_wr_i   (dat_wr && hit_addr),
            .dat_rd_i   (dat_rd && hit_addr),
            .din_i      (din),
            .live_i     (live_cnt[i*CNT_W +: CNT_W]),
            .rd_byte_o  (rd_bytes[i]),
            .mode_o     (cfg_mode[i*3 +: 3]),
            .bcd_o      (cfg_bcd[i]),
            .fmt_o      (cfg_fmt[i*2 +: 2]),
            .cfg_stb_o  (cfg_stb[i]),
            .load_stb_o (load_stb[i]),
            .load_val_o (load_val[i*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        d = q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dat_rd && addr == 2'(i)) d.dout = rd_bytes[i];
        end
        dout = q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_one_cfg_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cfg_stb));
    assert_cfg_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|cfg_stb) |-> $past(cfg_wr));
    assert_dout_moves_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dat_rd) |-> $stable(dout));

endmodule

// File: tb/timer_bus_regs_tb_top.sv
`timescale 1ns/1ps
module timer_bus_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [47:0] live_cnt = '0;
    logic [8:0]  cfg_mode;
    logic [2:0]  cfg_bcd, cfg_stb, load_stb;
    logic [5:0]  cfg_fmt;
    logic [47:0] load_val;

    int n_chk = 0, n_bad = 0;
    logic [2:0]  s_cfg, s_load;
    logic [47:0] s_val;

    always #10 clk = ~clk;

    timer_bus_regs dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .live_cnt(live_cnt),
        .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cfg_fmt(cfg_fmt),
        .cfg_stb(cfg_stb), .load_stb(load_stb), .load_val(load_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        cs_n = 0; wr_n = 0; rd_n = 1; addr = a; din = v;
        @(negedge clk);
        s_cfg = cfg_stb; s_load = load_stb; s_val = load_val;
        cs_n = 1; wr_n = 1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        cs_n = 0; rd_n = 0; wr_n = 1; addr = a;
        @(negedge clk);
        v = dout;
        cs_n = 1; rd_n = 1;
        @(negedge clk);
    endtask

    function automatic logic [2:0] fold(input logic [2:0] m);
        return (m == 3'd6) ? 3'd2 : (m == 3'd7) ? 3'd3 : m;
    endfunction

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0]  rb;
        logic [15:0] vals [5] = '{16'h0000, 16'h1234, 16'hFFFF, 16'hA55A, 16'h00FF};
        int cnt;

        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 mode", {23'd0, cfg_mode}, 32'd0);
        chk("R12 fmt", {26'd0, cfg_fmt}, {26'd0, 6'b010101});
        chk("R12 bcd/strobes", {23'd0, cfg_bcd, cfg_stb, load_stb}, 32'd0);
        chk("R12 dout", {24'd0, dout}, 32'd0);
        rst_n = 1;
        @(negedge clk);

        // R1, R2: mode and decimal sweep on every channel
        for (int ch = 0; ch < 3; ch++)
            for (int m = 0; m < 8; m++)
                for (int b = 0; b < 2; b++) begin
                    bus_wr(2'd3, {2'(ch), 2'b11, 3'(m), 1'(b)});
                    chk("R1 cfg_stb", {29'd0, s_cfg}, 32'(1 << ch));
                    chk("R2 mode", {29'd0, cfg_mode[ch*3 +: 3]}, {29'd0, fold(3'(m))});
                    chk("R2 bcd", {31'd0, cfg_bcd[ch]}, 32'(b));
                    chk("R2 fmt", {30'd0, cfg_fmt[ch*2 +: 2]}, 32'd3);
                end

        // R1: channel select 3 ignored
        bus_wr(2'd3, 8'b11_01_100_0);
        chk("R1 sel3 strobe", {29'd0, s_cfg}, 32'd0);
        chk("R1 sel3 fmt", {26'd0, cfg_fmt}, {26'd0, 6'b111111});

        // R3, R4, R5: count writes in each format
        for (int ch = 0; ch < 3; ch++)
            for (int f = 1; f < 4; f++) begin
                bus_wr(2'd3, {2'(ch), 2'(f), 4'b0000});
                for (int k = 0; k < 5; k++) begin
                    if (f == 1) begin
                        bus_wr(2'(ch), vals[k][7:0]);
                        chk("R3 load_stb", {29'd0, s_load}, 32'(1 << ch));
                        chk("R3 load_val", {16'd0, s_val[ch*16 +: 16]}, {24'd0, vals[k][7:0]});
                    end else if (f == 2) begin
                        bus_wr(2'(ch), vals[k][15:8]);
                        chk("R4 load_stb", {29'd0, s_load}, 32'(1 << ch));
                        chk("R4 load_val", {16'd0, s_val[ch*16 +: 16]}, {16'd0, vals[k][15:8], 8'h00});
                    end else begin
                        bus_wr(2'(ch), vals[k][7:0]);
                        chk("R5 no strobe after low", {29'd0, s_load}, 32'd0);
                        bus_wr(2'(ch), vals[k][15:8]);
                        chk("R5 load_stb", {29'd0, s_load}, 32'(1 << ch));
                        chk("R5 load_val", {16'd0, s_val[ch*16 +: 16]}, {16'd0, vals[k]});
                    end
                end
            end

        // R6: configuration word mid-pair resets byte order
        bus_wr(2'd3, 8'b01_11_000_0);
        bus_wr(2'd1, 8'h11);
        bus_wr(2'd3, 8'b01_11_010_0);
        bus_wr(2'd1, 8'h22);
        chk("R6 no strobe after restart", {29'd0, s_load}, 32'd0);
        bus_wr(2'd1, 8'h33);
        chk("R6 load_val", {16'd0, s_val[31:16]}, 32'h3322);

        // R7: live reads in each format
        live_cnt = {16'hC3B2, 16'hA190, 16'h8F7E};
        for (int ch = 0; ch < 3; ch++) begin
            logic [15:0] lv;
            lv = live_cnt[ch*16 +: 16];
            bus_wr(2'd3, {2'(ch), 2'b01, 4'b0000});
            bus_rd(2'(ch), rb); chk("R7 low only", {24'd0, rb}, {24'd0, lv[7:0]});
            bus_wr(2'd3, {2'(ch), 2'b10, 4'b0000});
            bus_rd(2'(ch), rb); chk("R7 high only", {24'd0, rb}, {24'd0, lv[15:8]});
            bus_wr(2'd3, {2'(ch), 2'b11, 4'b0000});
            for (int r = 0; r < 4; r++) begin
                bus_rd(2'(ch), rb);
                chk("R7 pair order", {24'd0, rb}, {24'd0, (r % 2 == 1) ? lv[15:8] : lv[7:0]});
            end
        end

        // R6: configuration word resets read order
        bus_wr(2'd3, 8'b00_11_000_0);
        bus_rd(2'd0, rb);
        bus_wr(2'd3, 8'b00_11_000_0);
        bus_rd(2'd0, rb);
        chk("R6 read order reset", {24'd0, rb}, 32'h7E);

        // R8, R10: snapshot on channel 2 in pair format
        bus_wr(2'd3, 8'b10_11_101_1);
        bus_wr(2'd3, 8'b10_00_000_0);
        chk("R10 no cfg strobe", {29'd0, s_cfg}, 32'd0);
        chk("R10 mode kept", {29'd0, cfg_mode[8:6]}, 32'd5);
        chk("R10 fmt/bcd kept", {29'd0, cfg_fmt[5:4], cfg_bcd[2]}, 32'b111);
        live_cnt[47:32] = 16'h0F0E;
        bus_rd(2'd2, rb); chk("R8 held low", {24'd0, rb}, 32'hB2);
        bus_rd(2'd2, rb); chk("R8 held high", {24'd0, rb}, 32'hC3);
        bus_rd(2'd2, rb); chk("R8 live after release", {24'd0, rb}, 32'h0E);
        bus_rd(2'd2, rb);

        // R9: second snapshot ignored
        bus_wr(2'd3, 8'b10_00_000_0);
        live_cnt[47:32] = 16'h5544;
        bus_wr(2'd3, 8'b10_00_000_0);
        live_cnt[47:32] = 16'h7766;
        bus_rd(2'd2, rb); chk("R9 first snapshot low", {24'd0, rb}, 32'h0E);
        bus_rd(2'd2, rb); chk("R9 first snapshot high", {24'd0, rb}, 32'h0F);

        // R8: single-byte format releases after one read
        bus_wr(2'd3, 8'b01_01_000_0);
        bus_wr(2'd3, 8'b01_00_000_0);
        live_cnt[31:16] = 16'h1357;
        bus_rd(2'd1, rb); chk("R8 held single", {24'd0, rb}, 32'h90);
        bus_rd(2'd1, rb); chk("R8 live single", {24'd0, rb}, 32'h57);

        // R11: ignored accesses and held strobes
        @(negedge clk);
        cs_n = 1; wr_n = 0; addr = 2'd1; din = 8'hAA;
        cnt = 0;
        repeat (3) begin @(negedge clk); if (load_stb != 0) cnt++; end
        chk("R11 no select", 32'(cnt), 32'd0);
        cs_n = 0; rd_n = 0; wr_n = 0;
        cnt = 0;
        repeat (3) begin @(negedge clk); if (load_stb != 0) cnt++; end
        chk("R11 both strobes", 32'(cnt), 32'd0);
        rd_n = 1; cs_n = 1; wr_n = 1;
        @(negedge clk);
        cs_n = 0; wr_n = 0; din = 8'h5C;
        cnt = 0;
        repeat (5) begin @(negedge clk); if (load_stb[1]) cnt++; end
        chk("R11 held write once", 32'(cnt), 32'd1);
        chk("R11 held write value", {16'd0, load_val[31:16]}, 32'h005C);
        cs_n = 1; wr_n = 1;
        repeat (2) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule